// File: doc/BRIEF.md
# Decimation-in-Time Transform Sequencer

This block is the control unit for a radix-2, decimation-in-time number theoretic transform of size N = 2^LOG_N. It computes no arithmetic: it tells an external butterfly datapath which pair of coefficients to read, which pair to write back, and when to restart or advance its twiddle stream. It does this for one butterfly every clock cycle, so each pass takes N/2 issue cycles.

A pulse on `start_i` starts a transform of LOG_N passes. The first pass reads its operands in bit-reversed order. Every pass writes in natural order. The write addresses are the natural read addresses, delayed by the datapath latency PIPE_DEPTH. When a pass ends, the sequencer stops issuing until the last result of that pass has been written. It then toggles the bank-select output that swaps the ping-pong memories and starts the next pass. A one-cycle `done_o` pulse marks the end of the transform.

Each pass takes N/2 + PIPE_DEPTH cycles, so a full transform takes LOG_N·(N/2 + PIPE_DEPTH) cycles. The twiddle generator is restarted at the start of every butterfly group. It uses `stage_o` to select the base root for the current pass.

Top module: `ntt_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_valid_o`, `wr_valid_o`, `tw_restart_o` and `tw_step_o` are 0, and `stage_o` and `flip_o` are 0.
- R2: A `start_i` that is high at a rising edge while the block is idle makes `busy_o` and `rd_valid_o` high in the next cycle, with `stage_o` = 0 and `flip_o` = 0.
- R3: In pass s (0-based), `rd_valid_o` is high for N/2 consecutive cycles. Butterfly j (0..N/2-1) is issued in the j-th of those cycles. With h = 2^s, its natural addresses are a = (j div h)·2h + (j mod h) and b = a + h. For s > 0 these natural addresses appear unchanged on `rd_addr_a_o` and `rd_addr_b_o`.
- R4: In pass 0 only, the read addresses are bit-reversed. Bit i of `rd_addr_a_o` is bit LOG_N-1-i of a, and `rd_addr_b_o` is formed from b in the same way.
- R5: Exactly PIPE_DEPTH cycles after each read, `wr_valid_o` is high and `wr_addr_a_o`/`wr_addr_b_o` carry the natural a and b of that butterfly. This holds in pass 0 as well.
- R6: After the last read of a pass, no read is issued for PIPE_DEPTH cycles. The next pass begins its reads in the cycle after the last write of the previous pass, so each pass lasts N/2 + PIPE_DEPTH cycles.
- R7: While busy, `stage_o` equals the current pass number. `flip_o` is 0 in pass 0 and toggles at each pass boundary, so it equals the pass number mod 2. It never changes in a cycle that has a write.
- R8: `tw_restart_o` is high with a read whose offset j mod h is 0. `tw_step_o` is high with every other read. Both are 0 when there is no read.
- R9: `done_o` is high for exactly one cycle: the cycle after the last write of pass LOG_N-1. `busy_o` is low in that cycle.
- R10: `start_i` has no effect while `busy_o` is high. The addresses, strobes and timing of the running transform are unchanged.
- R11: After `done_o`, `stage_o` holds LOG_N-1 and `flip_o` holds (LOG_N-1) mod 2 until the next start. A start in the `done_o` cycle is accepted and begins again from pass 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transform when idle |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | A butterfly read is issued this cycle |
| rd_addr_a_o | output | LOG_N | Read address of the lower operand |
| rd_addr_b_o | output | LOG_N | Read address of the upper operand |
| wr_valid_o | output | 1 | A butterfly result is written this cycle |
| wr_addr_a_o | output | LOG_N | Write address of the lower result |
| wr_addr_b_o | output | LOG_N | Write address of the upper result |
| tw_restart_o | output | 1 | Restart the twiddle stream for a new group |
| tw_step_o | output | 1 | Advance the twiddle stream by one root |
| stage_o | output | STAGE_W | Current pass number |
| flip_o | output | 1 | Ping-pong bank select |

## Verification
The read strobe and read addresses of the first butterfly appear in the cycle right after the edge that samples `start_i`. The writes follow exactly PIPE_DEPTH cycles after their reads. Pass p begins p·(N/2 + PIPE_DEPTH) cycles after the first read, and `done_o` comes LOG_N·(N/2 + PIPE_DEPTH) cycles after it. The bench derives every expected value from the cycle offset since start. It samples once per cycle at the falling edge and compares every output in every cycle of each run, including the cycle after `done_o`, where idle and held values are checked.

// File: rtl/ntt_seq_pkg.sv
package ntt_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ntt_bitrev.sv
module ntt_bitrev #(
  parameter int W = 5
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign out_o[i] = in_i[W-1-i];
  end
endmodule

// File: rtl/ntt_bfly_addr.sv
module ntt_bfly_addr #(
  parameter int LOG_N   = 5,
  parameter int STAGE_W = 3
) (
  input  logic [STAGE_W-1:0] stage_i,
  input  logic [LOG_N-2:0]   idx_i,
  output logic [LOG_N-1:0]   addr_a_o,
  output logic [LOG_N-1:0]   addr_b_o,
  output logic               grp_first_o
);
  logic [LOG_N-1:0] half_span;
  logic [LOG_N-1:0] mask;
  logic [LOG_N-1:0] idx_ext;
  logic [LOG_N-1:0] grp_part;
  logic [LOG_N-1:0] ofs_part;

  always_comb begin
    half_span   = {{(LOG_N-1){1'b0}}, 1'b1} << stage_i;
    mask        = half_span - 1'b1;
    idx_ext     = {1'b0, idx_i};
    ofs_part    = idx_ext & mask;
    // group g sits at g*2h: move group bits up by one
    grp_part    = (idx_ext & ~mask) << 1;
    addr_a_o    = grp_part | ofs_part;
    addr_b_o    = addr_a_o | half_span;
    grp_first_o = (ofs_part == '0);
  end
endmodule

// File: rtl/ntt_delay_pipe.sv
module ntt_delay_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = d_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap[i+1] <= '0;
      else         tap[i+1] <= tap[i];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/ntt_pass_fsm.sv
module ntt_pass_fsm
  import ntt_seq_pkg::*;
#(
  parameter int LOG_N      = 5,
  parameter int PIPE_DEPTH = 8,
  parameter int STAGE_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               issue_o,
  output logic [LOG_N-2:0]   idx_o,
  output logic [STAGE_W-1:0] stage_o,
  output logic               flip_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);
  localparam logic [LOG_N-2:0]   LAST_IDX   = {(LOG_N-1){1'b1}};
  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(LOG_N - 1);
  localparam logic [CNT_W-1:0]   LAST_DRAIN = CNT_W'(PIPE_DEPTH - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
      stage_o <= '0;
      flip_o  <= 1'b0;
      drain_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ISSUE;
            idx_o   <= '0;
            stage_o <= '0;
            flip_o  <= 1'b0;
          end
        end
        ST_ISSUE: begin
          idx_o <= idx_o + 1'b1;
          if (idx_o == LAST_IDX) begin
            state_q <= ST_DRAIN;
            drain_q <= '0;
          end
        end
        ST_DRAIN: begin
          drain_q <= drain_q + 1'b1;
          // last write of the pass leaves the pipe in this cycle
          if (drain_q == LAST_DRAIN) begin
            if (stage_o == LAST_STAGE) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              state_q <= ST_ISSUE;
              stage_o <= stage_o + 1'b1;
              flip_o  <= ~flip_o;
              idx_o   <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_o = (state_q == ST_ISSUE);
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/ntt_seq_ctrl.sv
module ntt_seq_ctrl #(
  parameter int LOG_N      = 5,
  parameter int PIPE_DEPTH = 8,
  parameter int STAGE_W    = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rd_valid_o,
  output logic [LOG_N-1:0]   rd_addr_a_o,
  output logic [LOG_N-1:0]   rd_addr_b_o,
  output logic               wr_valid_o,
  output logic [LOG_N-1:0]   wr_addr_a_o,
  output logic [LOG_N-1:0]   wr_addr_b_o,
  output logic               tw_restart_o,
  output logic               tw_step_o,
  output logic [STAGE_W-1:0] stage_o,
  output logic               flip_o
);
  localparam int WPIPE_W = 2 * LOG_N + 1;

  logic               issue;
  logic [LOG_N-2:0]   idx;
  logic [LOG_N-1:0]   nat_a, nat_b, rev_a, rev_b;
  logic               grp_first;
  logic [WPIPE_W-1:0] wpipe_in, wpipe_out;

  ntt_pass_fsm #(
    .LOG_N(LOG_N), .PIPE_DEPTH(PIPE_DEPTH), .STAGE_W(STAGE_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .issue_o (issue),
    .idx_o   (idx),
    .stage_o (stage_o),
    .flip_o  (flip_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  ntt_bfly_addr #(.LOG_N(LOG_N), .STAGE_W(STAGE_W)) u_addr (
    .stage_i     (stage_o),
    .idx_i       (idx),
    .addr_a_o    (nat_a),
    .addr_b_o    (nat_b),
    .grp_first_o (grp_first)
  );

  ntt_bitrev #(.W(LOG_N)) u_rev_a (.in_i(nat_a), .out_o(rev_a));
  ntt_bitrev #(.W(LOG_N)) u_rev_b (.in_i(nat_b), .out_o(rev_b));

  // first pass gathers operands in bit-reversed order
  assign rd_valid_o   = issue;
  assign rd_addr_a_o  = (stage_o == '0) ? rev_a : nat_a;
  assign rd_addr_b_o  = (stage_o == '0) ? rev_b : nat_b;
  assign tw_restart_o = issue & grp_first;
  assign tw_step_o    = issue & ~grp_first;

  assign wpipe_in = {issue, nat_a, nat_b};

  ntt_delay_pipe #(.W(WPIPE_W), .DEPTH(PIPE_DEPTH)) u_wpipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wpipe_in),
    .q_o    (wpipe_out)
  );

  assign wr_valid_o  = wpipe_out[WPIPE_W-1];
  assign wr_addr_a_o = wpipe_out[2*LOG_N-1:LOG_N];
  assign wr_addr_b_o = wpipe_out[LOG_N-1:0];
endmodule

// File: rtl/ntt_seq_ctrl_chk.sv
module ntt_seq_ctrl_chk #(
  parameter int LOG_N      = 5,
  parameter int PIPE_DEPTH = 8,
  parameter int STAGE_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               rd_valid_o,
  input logic [LOG_N-1:0]   rd_addr_a_o,
  input logic [LOG_N-1:0]   rd_addr_b_o,
  input logic               wr_valid_o,
  input logic [LOG_N-1:0]   wr_addr_a_o,
  input logic [LOG_N-1:0]   wr_addr_b_o,
  input logic               tw_restart_o,
  input logic               tw_step_o,
  input logic [STAGE_W-1:0] stage_o,
  input logic               flip_o
);
  localparam logic [LOG_N-1:0] TOP_BIT = {1'b1, {(LOG_N-1){1'b0}}};

  p_idle_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_valid_o);

  p_run_begins_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (stage_o == '0) && !flip_o);

  p_pair_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && (stage_o != '0) |->
      (rd_addr_b_o - rd_addr_a_o) == (LOG_N'(1) << stage_o));

  p_rev_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && (stage_o == '0) |-> (rd_addr_a_o ^ rd_addr_b_o) == TOP_BIT);

  p_wr_pair_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_addr_b_o - wr_addr_a_o) == (LOG_N'(1) << stage_o));

  p_flip_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flip_o) |-> !wr_valid_o);

  p_tw_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_restart_o || tw_step_o) |-> rd_valid_o && !(tw_restart_o && tw_step_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !wr_valid_o && !rd_valid_o);

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> stage_o >= $past(stage_o));
endmodule

bind ntt_seq_ctrl ntt_seq_ctrl_chk #(
  .LOG_N(LOG_N), .PIPE_DEPTH(PIPE_DEPTH), .STAGE_W(STAGE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_addr_a_o(rd_addr_a_o),
  .rd_addr_b_o(rd_addr_b_o), .wr_valid_o(wr_valid_o),
  .wr_addr_a_o(wr_addr_a_o), .wr_addr_b_o(wr_addr_b_o),
  .tw_restart_o(tw_restart_o), .tw_step_o(tw_step_o),
  .stage_o(stage_o), .flip_o(flip_o)
);

// File: tb/sim_ntt_seq_ctrl.sv
`timescale 1ns/1ps
module sim_ntt_seq_ctrl;
  localparam int LOG_N   = 5;
  localparam int DEPTH   = 8;
  localparam int STAGE_W = 3;
  localparam int HALF    = 1 << (LOG_N - 1);
  localparam int PERIOD  = HALF + DEPTH;
  localparam int TOTAL   = LOG_N * PERIOD;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, rd_valid_o, wr_valid_o, tw_restart_o, tw_step_o, flip_o;
  logic [LOG_N-1:0] rd_addr_a_o, rd_addr_b_o, wr_addr_a_o, wr_addr_b_o;
  logic [STAGE_W-1:0] stage_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  ntt_seq_ctrl #(.LOG_N(LOG_N), .PIPE_DEPTH(DEPTH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_addr_a_o(rd_addr_a_o),
    .rd_addr_b_o(rd_addr_b_o), .wr_valid_o(wr_valid_o),
    .wr_addr_a_o(wr_addr_a_o), .wr_addr_b_o(wr_addr_b_o),
    .tw_restart_o(tw_restart_o), .tw_step_o(tw_step_o),
    .stage_o(stage_o), .flip_o(flip_o)
  );

  task automatic chk(input string req, input int act, input int exp, input int c);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, c, act, exp);
    end
  endtask

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < LOG_N; i++) if (v[i]) r |= 1 << (LOG_N - 1 - i);
    return r;
  endfunction

  function automatic int nat_a(input int p, input int j);
    int h = 1 << p;
    return (j / h) * 2 * h + (j % h);
  endfunction

  // checks every output at cycle c (1 = first cycle after the start edge)
  task automatic check_cycle(input int c);
    int o = c - 1;
    int p = o / PERIOD;
    int r = o % PERIOD;
    if (p >= LOG_N) begin
      chk("R9 done", int'(done_o), 1, c);
      chk("R9 busy", int'(busy_o), 0, c);
      chk("R9 wr_valid", int'(wr_valid_o), 0, c);
      chk("R6 rd_valid", int'(rd_valid_o), 0, c);
    end else begin
      int h = 1 << p;
      chk("R9 done", int'(done_o), 0, c);
      chk("R2 busy", int'(busy_o), 1, c);
      chk("R7 stage", int'(stage_o), p, c);
      chk("R7 flip", int'(flip_o), p % 2, c);
      chk("R6 rd_valid", int'(rd_valid_o), (r < HALF) ? 1 : 0, c);
      if (r < HALF) begin
        int a = nat_a(p, r);
        int b = a + h;
        if (p == 0) begin
          chk("R4 rd_a", int'(rd_addr_a_o), rev(a), c);
          chk("R4 rd_b", int'(rd_addr_b_o), rev(b), c);
        end else begin
          chk("R3 rd_a", int'(rd_addr_a_o), a, c);
          chk("R3 rd_b", int'(rd_addr_b_o), b, c);
        end
        chk("R8 restart", int'(tw_restart_o), ((r % h) == 0) ? 1 : 0, c);
        chk("R8 step", int'(tw_step_o), ((r % h) != 0) ? 1 : 0, c);
      end else begin
        chk("R8 restart", int'(tw_restart_o), 0, c);
        chk("R8 step", int'(tw_step_o), 0, c);
      end
      chk("R5 wr_valid", int'(wr_valid_o), (r >= DEPTH) ? 1 : 0, c);
      if (r >= DEPTH) begin
        int wa = nat_a(p, r - DEPTH);
        chk("R5 wr_a", int'(wr_addr_a_o), wa, c);
        chk("R5 wr_b", int'(wr_addr_b_o), wa + h, c);
      end
    end
  endtask

  // pulse start unless already_started; optional start while busy at cycle poke;
  // chain raises start in the done cycle and returns before its first cycle
  task automatic run_transform(input bit already_started, input int poke, input bit chain);
    if (!already_started) begin
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int c = 1; c <= TOTAL + 1; c++) begin
      check_cycle(c);
      if (c == poke) start_i = 1'b1;          // R10
      else if (c == TOTAL + 1 && chain) start_i = 1'b1;  // R11
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    if (!chain) begin
      chk("R11 idle", int'(busy_o), 0, TOTAL + 2);
      chk("R11 stage held", int'(stage_o), LOG_N - 1, TOTAL + 2);
      chk("R11 flip held", int'(flip_o), (LOG_N - 1) % 2, TOTAL + 2);
      chk("R9 done single", int'(done_o), 0, TOTAL + 2);
    end
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    chk("R1 busy", int'(busy_o), 0, 0);
    chk("R1 done", int'(done_o), 0, 0);
    chk("R1 rd_valid", int'(rd_valid_o), 0, 0);
    chk("R1 wr_valid", int'(wr_valid_o), 0, 0);
    chk("R1 tw", int'(tw_restart_o | tw_step_o), 0, 0);
    chk("R1 stage", int'(stage_o), 0, 0);
    chk("R1 flip", int'(flip_o), 0, 0);
  endtask

  task automatic test_basic();
    run_transform(1'b0, 0, 1'b0);
  endtask

  task automatic test_start_while_busy();
    run_transform(1'b0, PERIOD + 3, 1'b0);  // R10: mid pass 1
    run_transform(1'b0, HALF + 2, 1'b0);    // R10: inside drain
  endtask

  task automatic test_back_to_back();
    run_transform(1'b0, 0, 1'b1);           // R11: start in done cycle
    run_transform(1'b1, 0, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_basic();
    test_start_while_busy();
    test_back_to_back();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule